// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the transmit side of an I2C bus master. The host places one byte at a time in a transmit buffer. The byte can be an address with its R/W bit, one half of a 10-bit address, or data. The engine then clocks the byte out on open-drain SCL and SDA lines, most significant bit first. It follows the byte with a ninth clock during which the addressed target may pull SDA low to acknowledge.

All bit timing comes from a reload counter. One phase lasts `div_i + 1` system clocks. Each bit spends one phase with SCL low, then one phase with SCL released. When the ninth clock ends, the counter stops and SCL stays held low until the host supplies the next byte.

The host also requests bus conditions through single-cycle strobes: start, repeated start and stop. Status is reported through four flags:
- buffer full
- write collision
- acknowledge status
- interrupt

The interrupt and collision flags are cleared by write-one strobes.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset both line enables are 0 (lines released), and the buffer-full, collision, acknowledge-status and interrupt flags are all 0.
- R2: A buffer write while the engine is idle or holding takes effect at the next clock edge. At that edge the buffer-full flag goes to 1, SCL is pulled low (scl_oe_o=1), and sda_oe_o becomes the inverse of the byte's bit 7.
- R3: The 8 bits go out MSB first. Each bit is held for one phase with SCL low and then one phase with SCL released, where a phase is div_i+1 clocks. The interrupt flag sets 18 phases after the accepting edge.
- R4: SDA does not change while SCL is released during the eight data bits.
- R5: The buffer-full flag clears at the eighth SCL falling edge, 16 phases after the accepting edge. SDA is released at that same edge.
- R6: At the end of the ninth clock's high phase, the SDA level is captured into ack_nack_o: 0 means acknowledged, 1 means not acknowledged. The value is kept until the next ninth clock.
- R7: After the ninth clock, SCL stays held low and SDA stays released, with no further activity, until the host acts.
- R8: A buffer write while a byte or a bus condition is in progress sets the collision flag and does not alter the byte being sent. The flag stays 1 until clr_wcol_i is pulsed.
- R9: A clr_irq_i pulse clears the interrupt flag, and a clr_wcol_i pulse clears the collision flag, on the next edge.
- R10: Start is accepted only when idle. It runs as SDA low with SCL released for one phase, then SCL low for one phase. The interrupt sets 2 phases after acceptance, with both lines left low.
- R11: Repeated start is accepted only while holding after a byte. Its four phases are:
  - SDA released, SCL low
  - both released
  - SDA low, SCL released
  - both low

  The interrupt sets 4 phases after acceptance.
- R12: Stop is accepted only while holding. Its three phases are:
  - both low
  - SCL released
  - both released

  The interrupt sets 3 phases after acceptance, and the engine returns to idle.
- R13: A condition request outside its accepted state is ignored. While holding, the priority is buffer write, then stop, then repeated start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 8 | Phase divider; a phase is div_i+1 clocks |
| wr_i | input | 1 | Transmit buffer write strobe |
| wdata_i | input | 8 | Byte to transmit |
| start_i | input | 1 | Start condition request |
| rstart_i | input | 1 | Repeated start request |
| stop_i | input | 1 | Stop condition request |
| clr_irq_i | input | 1 | Clear interrupt flag |
| clr_wcol_i | input | 1 | Clear collision flag |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| bf_o | output | 1 | Buffer full flag |
| wcol_o | output | 1 | Write collision flag |
| ack_nack_o | output | 1 | Acknowledge status: 0 ack, 1 nack |
| irq_o | output | 1 | Interrupt flag |

## Verification
The bench sweeps the divider from 0 upward and times the interrupt and the buffer-full drop in exact clocks. A design that clears buffer-full at the end of the ninth clock, or that is off by one in the reload, lands on the wrong cycle. A collision write in the middle of a byte must leave the received byte intact; a design that loads the buffer anyway corrupts the remaining bits. Condition requests arrive in the wrong state and also two at once. A design that honours a stop while idle, or picks repeated start over stop, moves lines that must stay put. The bench also holds the engine after a byte to confirm that SCL stays low and that the previous acknowledge status survives a repeated start.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_BIT_LO, S_BIT_HI, S_ACK_LO, S_ACK_HI, S_COND
  } tx_st_e;

  typedef enum logic [1:0] {C_START, C_RSTART, C_STOP} cond_e;

  // {scl_oe, sda_oe} driven in each step of a bus condition
  function automatic logic [1:0] cond_lines(cond_e c, logic [1:0] step);
    logic [1:0] r;
    r = 2'b00;
    case (c)
      C_START:  r = (step == 2'd0) ? 2'b01 : 2'b11;
      C_RSTART: case (step)
                  2'd0: r = 2'b10;
                  2'd1: r = 2'b00;
                  2'd2: r = 2'b01;
                  default: r = 2'b11;
                endcase
      C_STOP:   case (step)
                  2'd0: r = 2'b11;
                  2'd1: r = 2'b01;
                  default: r = 2'b00;
                endcase
      default:  r = 2'b00;
    endcase
    return r;
  endfunction

  function automatic logic [1:0] cond_last(cond_e c);
    case (c)
      C_START:  return 2'd1;
      C_RSTART: return 2'd3;
      default:  return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/i2c_baud_tick.sv
module i2c_baud_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i || cnt_q == '0) cnt_q <= div_i;
    else                            cnt_q <= cnt_q - 1'b1;
  end

  // R3: with a nonzero divider, ticks are never back to back
  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/i2c_tx_flags.sv
module i2c_tx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bf_set_i,
  input  logic bf_clr_i,
  input  logic wcol_set_i,
  input  logic wcol_clr_i,
  input  logic irq_set_i,
  input  logic irq_clr_i,
  input  logic ack_ld_i,
  input  logic ack_line_i,
  output logic bf_o,
  output logic wcol_o,
  output logic irq_o,
  output logic ack_nack_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bf_o       <= 1'b0;
      wcol_o     <= 1'b0;
      irq_o      <= 1'b0;
      ack_nack_o <= 1'b0;
    end else begin
      if (bf_set_i)        bf_o <= 1'b1;
      else if (bf_clr_i)   bf_o <= 1'b0;
      if (wcol_set_i)      wcol_o <= 1'b1;
      else if (wcol_clr_i) wcol_o <= 1'b0;
      if (irq_set_i)       irq_o <= 1'b1;
      else if (irq_clr_i)  irq_o <= 1'b0;
      if (ack_ld_i)        ack_nack_o <= ack_line_i;
    end
  end

  a_r8_wcol_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcol_o && !wcol_clr_i) |=> wcol_o);
  a_r6_ack_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_ld_i |=> $stable(ack_nack_o));
endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master
  import i2c_tx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              start_i,
  input  logic              rstart_i,
  input  logic              stop_i,
  input  logic              clr_irq_i,
  input  logic              clr_wcol_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              bf_o,
  output logic              wcol_o,
  output logic              ack_nack_o,
  output logic              irq_o
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  tx_st_e            st_q;
  cond_e             cond_q;
  logic [1:0]        step_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  bit_q;
  logic              scl_oe_q, sda_oe_q;
  logic              tick, quiet, accept, collide, bf_clr, ack_ld, cond_done;

  assign quiet     = (st_q == S_IDLE) || (st_q == S_HOLD);
  assign accept    = quiet && wr_i;
  assign collide   = !quiet && wr_i;
  assign bf_clr    = (st_q == S_BIT_HI) && tick && (bit_q == LAST_BIT);
  assign ack_ld    = (st_q == S_ACK_HI) && tick;
  assign cond_done = (st_q == S_COND) && tick && (step_q == cond_last(cond_q));

  i2c_baud_tick #(.DIV_W(DIV_W)) u_baud (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(!quiet), .div_i(div_i), .tick_o(tick)
  );

  i2c_tx_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bf_set_i   (accept),
    .bf_clr_i   (bf_clr),
    .wcol_set_i (collide),
    .wcol_clr_i (clr_wcol_i),
    .irq_set_i  (ack_ld || cond_done),
    .irq_clr_i  (clr_irq_i),
    .ack_ld_i   (ack_ld),
    .ack_line_i (sda_i),
    .bf_o       (bf_o),
    .wcol_o     (wcol_o),
    .irq_o      (irq_o),
    .ack_nack_o (ack_nack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      cond_q   <= C_START;
      step_q   <= '0;
      sh_q     <= '0;
      bit_q    <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE, S_HOLD: begin
          if (wr_i) begin
            sh_q     <= wdata_i;
            bit_q    <= '0;
            scl_oe_q <= 1'b1;
            sda_oe_q <= ~wdata_i[DATA_W-1];
            st_q     <= S_BIT_LO;
          end else if ((st_q == S_IDLE && start_i) ||
                       (st_q == S_HOLD && (stop_i || rstart_i))) begin
            // hold: stop outranks repeated start
            cond_q <= (st_q == S_IDLE) ? C_START : (stop_i ? C_STOP : C_RSTART);
            step_q <= '0;
            {scl_oe_q, sda_oe_q} <= cond_lines((st_q == S_IDLE) ? C_START :
                                     (stop_i ? C_STOP : C_RSTART), 2'd0);
            st_q   <= S_COND;
          end
        end
        S_BIT_LO: if (tick) begin
          scl_oe_q <= 1'b0;
          st_q     <= S_BIT_HI;
        end
        S_BIT_HI: if (tick) begin
          scl_oe_q <= 1'b1;
          if (bit_q == LAST_BIT) begin
            sda_oe_q <= 1'b0;
            st_q     <= S_ACK_LO;
          end else begin
            bit_q    <= bit_q + 1'b1;
            sh_q     <= sh_q << 1;
            sda_oe_q <= ~sh_q[DATA_W-2];
            st_q     <= S_BIT_LO;
          end
        end
        S_ACK_LO: if (tick) begin
          scl_oe_q <= 1'b0;
          st_q     <= S_ACK_HI;
        end
        S_ACK_HI: if (tick) begin
          scl_oe_q <= 1'b1;
          st_q     <= S_HOLD;
        end
        S_COND: if (tick) begin
          if (cond_done) begin
            st_q <= (cond_q == C_STOP) ? S_IDLE : S_HOLD;
          end else begin
            step_q <= step_q + 1'b1;
            {scl_oe_q, sda_oe_q} <= cond_lines(cond_q, step_q + 1'b1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;

  a_r2_accept_sets_bf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (bf_o && scl_oe_o));
  a_r4_sda_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_BIT_HI && $past(st_q == S_BIT_HI)) |-> $stable(sda_oe_o));
  a_r5_bf_clear_in_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_ACK_LO || st_q == S_ACK_HI) |-> (!bf_o && !sda_oe_o));
  a_r7_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_HOLD && $past(st_q == S_HOLD)) |-> ($stable(scl_oe_o) && $stable(sda_oe_o)));
  a_r8_collide_keeps_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (collide && st_q == S_BIT_LO) |=> (st_q == S_BIT_LO || st_q == S_BIT_HI));
endmodule

// File: tb/sim_i2c_tx_master.sv
module sim_i2c_tx_master;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] div_i = 8'd3, wdata_i = 8'h00;
  logic       wr_i = 0, start_i = 0, rstart_i = 0, stop_i = 0, clr_irq_i = 0, clr_wcol_i = 0;
  logic       sda_i, scl_oe_o, sda_oe_o, bf_o, wcol_o, ack_nack_o, irq_o;
  logic       slave_pull = 0, want_ack = 0;

  int total = 0, bad = 0;
  bit done = 0;

  // monitor state
  int         rises = 0, unstable = 0;
  logic [7:0] rx = 0;
  bit         fall_hi = 0, rise_hi = 0;
  logic       prev_scl = 1, prev_sda = 1;
  wire        scl_line = !scl_oe_o;

  assign sda_i = !(sda_oe_o || slave_pull);

  always #5 clk_i = ~clk_i;

  i2c_tx_master u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .start_i(start_i), .rstart_i(rstart_i), .stop_i(stop_i), .clr_irq_i(clr_irq_i),
    .clr_wcol_i(clr_wcol_i), .sda_i(sda_i), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .bf_o(bf_o), .wcol_o(wcol_o), .ack_nack_o(ack_nack_o), .irq_o(irq_o)
  );

  always @(negedge clk_i) begin
    if (scl_line && !prev_scl) begin
      if (rises < 8) rx = {rx[6:0], sda_i};
      rises = rises + 1;
    end
    if (!scl_line && prev_scl && rises == 8) slave_pull = want_ack;
    if (scl_line && prev_scl && sda_i != prev_sda) begin
      unstable = unstable + 1;
      if (prev_sda && !sda_i) fall_hi = 1;
      if (!prev_sda && sda_i) rise_hi = 1;
    end
    prev_scl = scl_line;
    prev_sda = sda_i;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {div, data, ack}
  localparam logic [16:0] VECS [6] = '{
    {8'd3, 8'hA5, 1'b1}, {8'd0, 8'h3C, 1'b0}, {8'd1, 8'hFF, 1'b1},
    {8'd7, 8'h00, 1'b1}, {8'd2, 8'h81, 1'b0}, {8'd0, 8'h5A, 1'b0}
  };

  task automatic send_byte(input logic [7:0] dv, input logic [7:0] data,
                           input logic ack, input bit coll);
    int n, t, bf_n, sda_at_bf;
    t = dv + 1;
    div_i = dv; want_ack = ack; rises = 0; unstable = 0; rx = 0;
    @(negedge clk_i); wr_i = 1; wdata_i = data;
    @(negedge clk_i); wr_i = 0; n = 1;
    chk("R2 bf", bf_o, 1);
    chk("R2 scl", scl_oe_o, 1);
    chk("R2 sda msb", sda_oe_o, !data[7]);
    bf_n = 0; sda_at_bf = -1;
    while (!irq_o && n < 5000) begin
      if (!bf_o && bf_n == 0) begin bf_n = n; sda_at_bf = sda_oe_o; end
      if (coll && n == 5) begin wr_i = 1; wdata_i = ~data; end
      if (coll && n == 6) begin wr_i = 0; chk("R8 wcol set", wcol_o, 1); end
      @(negedge clk_i); n++;
    end
    chk("R3 irq time", n, 18 * t + 1);
    chk("R5 bf clear time", bf_n, 16 * t + 1);
    chk("R5 sda released", sda_at_bf, 0);
    chk("R3 byte", rx, data);
    chk("R4 stable", unstable, 0);
    chk("R6 ack", ack_nack_o, !ack);
    slave_pull = 0;
  endtask

  task automatic cond(input string req, input int which, input int phases,
                      input int e_scl, input int e_sda);
    int n;
    fall_hi = 0; rise_hi = 0;
    @(negedge clk_i);
    start_i = (which == 0); rstart_i = (which == 1 || which == 3); stop_i = (which >= 2);
    @(negedge clk_i); start_i = 0; rstart_i = 0; stop_i = 0; n = 1;
    while (!irq_o && n < 5000) begin @(negedge clk_i); n++; end
    chk({req, " time"}, n, phases * (div_i + 1) + 1);
    chk({req, " scl"}, scl_oe_o, e_scl);
    chk({req, " sda"}, sda_oe_o, e_sda);
    if (which >= 2) chk({req, " rise hi"}, rise_hi, 1);
    else            chk({req, " fall hi"}, fall_hi, 1);
  endtask

  task automatic clear_irq();
    @(negedge clk_i); clr_irq_i = 1;
    @(negedge clk_i); clr_irq_i = 0;
    chk("R9 irq clear", irq_o, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 scl", scl_oe_o, 0); chk("R1 sda", sda_oe_o, 0);
    chk("R1 bf", bf_o, 0); chk("R1 wcol", wcol_o, 0);
    chk("R1 ack", ack_nack_o, 0); chk("R1 irq", irq_o, 0);
    rst_ni = 1;
    // R13: stop while idle is ignored
    @(negedge clk_i); stop_i = 1; rstart_i = 1;
    @(negedge clk_i); stop_i = 0; rstart_i = 0;
    repeat (10) @(negedge clk_i);
    chk("R13 idle stop scl", scl_oe_o, 0);
    chk("R13 idle stop irq", irq_o, 0);
    // R10 start
    div_i = 8'd3;
    cond("R10 start", 0, 2, 1, 1);
    clear_irq();
    for (int i = 0; i < 6; i++) begin
      send_byte(VECS[i][16:9], VECS[i][8:1], VECS[i][0], 0);
      clear_irq();
    end
    // R8 collision mid-byte
    send_byte(8'd2, 8'hC3, 1'b1, 1);
    chk("R8 wcol sticky", wcol_o, 1);
    clear_irq();
    @(negedge clk_i); clr_wcol_i = 1;
    @(negedge clk_i); clr_wcol_i = 0;
    chk("R9 wcol clear", wcol_o, 0);
    // R7 hold + R13 start ignored in hold
    send_byte(8'd1, 8'h96, 1'b0, 0);
    clear_irq();
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
    repeat (20) @(negedge clk_i);
    chk("R7 hold scl", scl_oe_o, 1);
    chk("R7 hold sda", sda_oe_o, 0);
    chk("R13 start ignored irq", irq_o, 0);
    chk("R6 ack persists", ack_nack_o, 1);
    // R11 repeated start; ack status persists across it
    div_i = 8'd2;
    cond("R11 rstart", 1, 4, 1, 1);
    chk("R6 ack after rstart", ack_nack_o, 1);
    clear_irq();
    send_byte(8'd2, 8'h42, 1'b1, 0);
    clear_irq();
    // R12 stop with simultaneous rstart: stop wins (R13)
    cond("R12 stop", 3, 3, 0, 0);
    clear_irq();
    repeat (10) @(negedge clk_i);
    chk("R12 idle scl", scl_oe_o, 0);
    chk("R12 idle sda", sda_oe_o, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule